// File: doc/BRIEF.md
# Reset Boot Sequencer with ROM Image Copy

This block decides how the processor core leaves external reset. In the first clock after reset it samples a two-bit boot-mode selection and holds the core's stall output high until startup work is finished. Three startup flavours exist. Direct start releases the core at once, or after the SDRAM controller reports ready when SDRAM is fitted. ROM copy streams a fixed-size image byte by byte from an 8-bit asynchronous external memory and writes it as packed words into internal memory from address zero. Host start waits for an external host to set a start flag.

The ROM copy runs before the external memory interface has been configured, so every byte access uses fixed, conservative setup, strobe and hold counts taken from parameters. The chip select stays low for the whole image, and the read addresses rise from a base. The bytes are packed low byte first into each word. When the last word has been written, the stall drops and a one-cycle done pulse marks the release. The host start flag doubles as a software-visible interrupt source. It can only be re-armed once software has cleared it, and it raises no interrupt while the core is stalled.

Top module: `startup_boot_ctrl`

## Requirements
- R1: The boot mode is taken from `boot_mode_i` in the first clock after reset is released; 2'b00 selects direct start, 2'b01 host start, 2'b10 ROM copy, and the unused code 2'b11 behaves as direct start. Later changes of `boot_mode_i` have no effect until the next reset.
- R2: During reset and until startup completes, `cpu_stall_o` is 1, `rom_cs_n_o` and `rom_oe_n_o` are 1, and `mem_we_o`, `boot_done_o`, `host_start_flag_o` and `cpu_start_int_o` are 0; once `cpu_stall_o` falls it stays low until the next reset.
- R3: In direct start with `sdram_used_i` low, the stall is released within three clocks of reset release with no external read; with `sdram_used_i` high, the stall is held until `sdram_ready_i` is seen high.
- R4: In ROM copy, exactly IMAGE_BYTES bytes are read at addresses ROM_BASE, ROM_BASE+1, ... in increasing order, with `rom_cs_n_o` low continuously for IMAGE_BYTES*(RD_SETUP+RD_STROBE+RD_HOLD) clocks.
- R5: Each byte access has RD_SETUP clocks with `rom_oe_n_o` high, RD_STROBE clocks with `rom_oe_n_o` low and RD_HOLD clocks with `rom_oe_n_o` high; `rom_oe_n_o` is low only while `rom_cs_n_o` is low, and the byte is captured at the end of the strobe.
- R6: Every WORD_BYTES bytes produce one `mem_we_o` pulse; the word written at byte address 4k is {byte[4k+3], byte[4k+2], byte[4k+1], byte[4k]} with byte[i] read from ROM_BASE+i, `mem_addr_o` carrying the byte address (low two bits 0).
- R7: One clock after the last byte's hold ends, the stall drops; no ROM access is issued after that.
- R8: In host start the stall is held until the start flag is set; setting the flag in any other mode does not change when the stall is released.
- R9: `host_start_set_i` sets the flag only if it is clear; `host_start_clr_i` clears it and wins over a set in the same clock. A set that takes the flag from 0 to 1 produces a one-clock `cpu_start_int_o` only when the core is not stalled; no interrupt follows a set while the flag is still 1.
- R10: `boot_done_o` is a single one-clock pulse per reset, in the clock where `cpu_stall_o` first goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| boot_mode_i | input | 2 | Boot-mode selection, sampled after reset |
| sdram_used_i | input | 1 | SDRAM fitted; direct start waits for ready |
| sdram_ready_i | input | 1 | SDRAM initialisation complete |
| rom_cs_n_o | output | 1 | External ROM chip select, active low |
| rom_oe_n_o | output | 1 | External ROM read strobe, active low |
| rom_addr_o | output | ROM_ADDR_W | External ROM byte address |
| rom_data_i | input | 8 | External ROM read data |
| mem_we_o | output | 1 | Internal memory write enable |
| mem_addr_o | output | $clog2(IMAGE_BYTES) | Internal memory byte address |
| mem_wdata_o | output | 8*WORD_BYTES | Internal memory write data |
| host_start_set_i | input | 1 | Host write of 1 to the start flag |
| host_start_clr_i | input | 1 | Software clear of the start flag |
| host_start_flag_o | output | 1 | Current start flag value |
| cpu_start_int_o | output | 1 | One-clock start interrupt to the core |
| cpu_stall_o | output | 1 | Core stall |
| boot_done_o | output | 1 | One-clock pulse at stall release |

## Verification
Some properties hold in every clock, and the assertions check these. The stall never comes back once dropped, and the ROM is never selected after release. The read strobe only happens under chip select, and every write is word aligned. The done pulse coincides with the release, and the end of the ROM burst is followed at once by release. A start interrupt never follows a stalled clock. Other behaviour depends on a whole scenario, and only the bench's scenarios show it. That covers which mode was latched and that later mode changes are ignored, and the exact burst length. It also covers the byte order inside each word, the data content of the copied image, and the release delays relative to SDRAM ready and the host flag.

// File: rtl/startup_boot_pkg.sv
package startup_boot_pkg;

   typedef enum logic [1:0] {
      MODE_DIRECT = 2'b00,
      MODE_HOST   = 2'b01,
      MODE_ROM    = 2'b10,
      MODE_RSVD   = 2'b11
   } boot_mode_e;

   typedef enum logic [2:0] {
      SQ_SAMPLE,
      SQ_WAIT_MEM,
      SQ_COPY,
      SQ_WAIT_HOST,
      SQ_RUN
   } seq_state_e;

   typedef enum logic [1:0] {
      PH_SETUP,
      PH_STROBE,
      PH_HOLD
   } rd_phase_e;

   // reserved code falls back to direct start
   function automatic boot_mode_e decode_mode(input logic [1:0] raw);
      boot_mode_e m;
      m = boot_mode_e'(raw);
      if (m == MODE_RSVD) m = MODE_DIRECT;
      return m;
   endfunction

endpackage

// File: rtl/rom_copy_engine.sv
module rom_copy_engine
   import startup_boot_pkg::*;
#(
   parameter int IMAGE_BYTES = 65536,
   parameter int WORD_BYTES  = 4,
   parameter int ADDR_W      = 24,
   parameter int unsigned ROM_BASE = 0,
   parameter int SETUP_CYC   = 4,
   parameter int STROBE_CYC  = 16,
   parameter int HOLD_CYC    = 4,
   localparam int CNT_W      = $clog2(IMAGE_BYTES),
   localparam int WORD_W     = 8 * WORD_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              rd_cs_n_o,
   output logic              rd_oe_n_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i,
   output logic              wr_en_o,
   output logic [CNT_W-1:0]  wr_addr_o,
   output logic [WORD_W-1:0] wr_data_o,
   output logic              done_o
);

   localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
   localparam int MAX_T = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
   localparam int TIM_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;
   localparam int LANE_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

   if (IMAGE_BYTES % WORD_BYTES != 0) begin : g_chk_image
      $error("IMAGE_BYTES must be a multiple of WORD_BYTES");
   end
   if ((WORD_BYTES & (WORD_BYTES - 1)) != 0 || WORD_BYTES < 2) begin : g_chk_word
      $error("WORD_BYTES must be a power of two of at least 2");
   end
   if (SETUP_CYC < 1 || STROBE_CYC < 1 || HOLD_CYC < 1) begin : g_chk_tim
      $error("each read timing phase needs at least one cycle");
   end
   if (ADDR_W < CNT_W) begin : g_chk_addr
      $error("ADDR_W too narrow for the image");
   end

   logic             busy_q;
   rd_phase_e        ph_q;
   logic [TIM_W-1:0] tick_q;
   logic [CNT_W-1:0] cnt_q;
   logic [TIM_W-1:0] tick_lim;
   logic             ph_last, strobe_last, hold_last, last_byte;
   logic [LANE_W-1:0] lane_sel;
   logic [WORD_W-1:0] word_c;

   always_comb begin
      unique case (ph_q)
         PH_SETUP:  tick_lim = TIM_W'(SETUP_CYC - 1);
         PH_STROBE: tick_lim = TIM_W'(STROBE_CYC - 1);
         default:   tick_lim = TIM_W'(HOLD_CYC - 1);
      endcase
   end

   assign ph_last     = busy_q && (tick_q == tick_lim);
   assign strobe_last = ph_last && (ph_q == PH_STROBE);
   assign hold_last   = ph_last && (ph_q == PH_HOLD);
   assign last_byte   = (cnt_q == CNT_W'(IMAGE_BYTES - 1));
   assign lane_sel    = cnt_q[LANE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ph_q   <= PH_SETUP;
         tick_q <= '0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q <= 1'b1;
            ph_q   <= PH_SETUP;
            tick_q <= '0;
            cnt_q  <= '0;
         end
      end else if (ph_last) begin
         tick_q <= '0;
         unique case (ph_q)
            PH_SETUP:  ph_q <= PH_STROBE;
            PH_STROBE: ph_q <= PH_HOLD;
            default: begin
               ph_q  <= PH_SETUP;
               cnt_q <= cnt_q + 1'b1;
               if (last_byte) busy_q <= 1'b0;
            end
         endcase
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end

   // one capture register per byte lane, low lane first
   for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  lane_q <= '0;
         else if (strobe_last && lane_sel == LANE_W'(l)) lane_q <= rd_data_i;
      end
      assign word_c[8*l +: 8] = lane_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
         done_o    <= 1'b0;
      end else begin
         wr_en_o   <= hold_last && (lane_sel == LANE_W'(WORD_BYTES - 1));
         wr_addr_o <= cnt_q - CNT_W'(WORD_BYTES - 1);
         wr_data_o <= word_c;
         done_o    <= hold_last && last_byte;
      end
   end

   assign rd_cs_n_o = !busy_q;
   assign rd_oe_n_o = !(busy_q && ph_q == PH_STROBE);
   assign rd_addr_o = ADDR_W'(ROM_BASE) + ADDR_W'(cnt_q);

endmodule

// File: rtl/host_start_flag.sv
module host_start_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic stall_i,
   output logic flag_o,
   output logic int_o
);

   logic arm;
   assign arm = set_i && !flag_o && !clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         int_o  <= 1'b0;
      end else begin
         if (clr_i)    flag_o <= 1'b0;
         else if (arm) flag_o <= 1'b1;
         int_o <= arm && !stall_i;
      end
   end

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
   import startup_boot_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_raw_i,
   input  logic       sdram_used_i,
   input  logic       sdram_ready_i,
   input  logic       host_flag_i,
   input  logic       copy_done_i,
   output logic       copy_start_o,
   output logic       stall_o,
   output logic       done_o
);

   seq_state_e state_q, state_d;
   boot_mode_e mode_c;

   assign mode_c = decode_mode(mode_raw_i);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_SAMPLE: begin
            unique case (mode_c)
               MODE_ROM:  state_d = SQ_COPY;
               MODE_HOST: state_d = SQ_WAIT_HOST;
               default:   state_d = SQ_WAIT_MEM;
            endcase
         end
         SQ_WAIT_MEM:  if (!sdram_used_i || sdram_ready_i) state_d = SQ_RUN;
         SQ_COPY:      if (copy_done_i) state_d = SQ_RUN;
         SQ_WAIT_HOST: if (host_flag_i) state_d = SQ_RUN;
         default:      state_d = SQ_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_SAMPLE;
         done_o  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_o  <= (state_d == SQ_RUN) && (state_q != SQ_RUN);
      end
   end

   assign copy_start_o = (state_q == SQ_SAMPLE) && (mode_c == MODE_ROM);
   assign stall_o      = (state_q != SQ_RUN);

endmodule

// File: rtl/startup_boot_ctrl.sv
module startup_boot_ctrl #(
   parameter int IMAGE_BYTES = 65536,
   parameter int WORD_BYTES  = 4,
   parameter int ROM_ADDR_W  = 24,
   parameter int unsigned ROM_BASE = 0,
   parameter int RD_SETUP    = 4,
   parameter int RD_STROBE   = 16,
   parameter int RD_HOLD     = 4,
   localparam int MEM_AW     = $clog2(IMAGE_BYTES),
   localparam int WORD_W     = 8 * WORD_BYTES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            boot_mode_i,
   input  logic                  sdram_used_i,
   input  logic                  sdram_ready_i,
   output logic                  rom_cs_n_o,
   output logic                  rom_oe_n_o,
   output logic [ROM_ADDR_W-1:0] rom_addr_o,
   input  logic [7:0]            rom_data_i,
   output logic                  mem_we_o,
   output logic [MEM_AW-1:0]     mem_addr_o,
   output logic [WORD_W-1:0]     mem_wdata_o,
   input  logic                  host_start_set_i,
   input  logic                  host_start_clr_i,
   output logic                  host_start_flag_o,
   output logic                  cpu_start_int_o,
   output logic                  cpu_stall_o,
   output logic                  boot_done_o
);

   logic copy_start, copy_done;

   boot_sequencer i_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_raw_i    (boot_mode_i),
      .sdram_used_i  (sdram_used_i),
      .sdram_ready_i (sdram_ready_i),
      .host_flag_i   (host_start_flag_o),
      .copy_done_i   (copy_done),
      .copy_start_o  (copy_start),
      .stall_o       (cpu_stall_o),
      .done_o        (boot_done_o)
   );

   rom_copy_engine #(
      .IMAGE_BYTES (IMAGE_BYTES),
      .WORD_BYTES  (WORD_BYTES),
      .ADDR_W      (ROM_ADDR_W),
      .ROM_BASE    (ROM_BASE),
      .SETUP_CYC   (RD_SETUP),
      .STROBE_CYC  (RD_STROBE),
      .HOLD_CYC    (RD_HOLD)
   ) i_copy (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (copy_start),
      .rd_cs_n_o (rom_cs_n_o),
      .rd_oe_n_o (rom_oe_n_o),
      .rd_addr_o (rom_addr_o),
      .rd_data_i (rom_data_i),
      .wr_en_o   (mem_we_o),
      .wr_addr_o (mem_addr_o),
      .wr_data_o (mem_wdata_o),
      .done_o    (copy_done)
   );

   host_start_flag i_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (host_start_set_i),
      .clr_i   (host_start_clr_i),
      .stall_i (cpu_stall_o),
      .flag_o  (host_start_flag_o),
      .int_o   (cpu_start_int_o)
   );

endmodule

// File: rtl/startup_boot_chk.sv
module startup_boot_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rom_cs_n_o,
   input logic       rom_oe_n_o,
   input logic       mem_we_o,
   input logic [1:0] mem_addr_lo,
   input logic       host_start_clr_i,
   input logic       host_start_flag_o,
   input logic       cpu_start_int_o,
   input logic       cpu_stall_o,
   input logic       boot_done_o
);

   a_r2_stall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_stall_o |=> !cpu_stall_o);

   a_r7_no_read_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_stall_o |-> rom_cs_n_o);

   a_r7_burst_end_releases: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rom_cs_n_o) |=> !cpu_stall_o);

   a_r5_strobe_under_select: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_oe_n_o |-> !rom_cs_n_o);

   a_r6_write_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (mem_addr_lo == 2'b00) && cpu_stall_o);

   a_r10_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_stall_o) |-> boot_done_o);

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done_o |=> !boot_done_o);

   a_r9_int_only_unstalled: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_start_int_o |-> !$past(cpu_stall_o) && host_start_flag_o);

   a_r9_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
      host_start_flag_o && !host_start_clr_i |=> host_start_flag_o);

endmodule

bind startup_boot_ctrl startup_boot_chk i_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .rom_cs_n_o        (rom_cs_n_o),
   .rom_oe_n_o        (rom_oe_n_o),
   .mem_we_o          (mem_we_o),
   .mem_addr_lo       (mem_addr_o[1:0]),
   .host_start_clr_i  (host_start_clr_i),
   .host_start_flag_o (host_start_flag_o),
   .cpu_start_int_o   (cpu_start_int_o),
   .cpu_stall_o       (cpu_stall_o),
   .boot_done_o       (boot_done_o)
);

// File: tb/test_startup_boot_ctrl.sv
`timescale 1ns/1ps
module test_startup_boot_ctrl;

   localparam int IB    = 32;
   localparam int WB    = 4;
   localparam int AW    = 16;
   localparam int BASE  = 16'h0400;
   localparam int TS    = 2;
   localparam int TT    = 3;
   localparam int TH    = 1;
   localparam int NW    = IB / WB;
   localparam int MAW   = $clog2(IB);
   localparam int BURST = IB * (TS + TT + TH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] boot_mode = 2'b00;
   logic sdram_used = 1'b0, sdram_ready = 1'b0;
   logic host_set = 1'b0, host_clr = 1'b0;
   logic rom_cs_n, rom_oe_n, mem_we, flag, cpu_int, stall, done;
   logic [AW-1:0] rom_addr;
   logic [7:0] rom_data;
   logic [MAW-1:0] mem_addr;
   logic [31:0] mem_wdata;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] rom_byte(input int a);
      return 8'(((a * 29) + 8'h5A) ^ (a >> 3));
   endfunction

   assign rom_data = rom_oe_n ? 8'h00 : rom_byte(int'(rom_addr));

   startup_boot_ctrl #(
      .IMAGE_BYTES(IB), .WORD_BYTES(WB), .ROM_ADDR_W(AW), .ROM_BASE(BASE),
      .RD_SETUP(TS), .RD_STROBE(TT), .RD_HOLD(TH)
   ) i_startup_boot_ctrl (
      .clk(clk), .rst_n(rst_n), .boot_mode_i(boot_mode),
      .sdram_used_i(sdram_used), .sdram_ready_i(sdram_ready),
      .rom_cs_n_o(rom_cs_n), .rom_oe_n_o(rom_oe_n), .rom_addr_o(rom_addr),
      .rom_data_i(rom_data), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .host_start_set_i(host_set),
      .host_start_clr_i(host_clr), .host_start_flag_o(flag),
      .cpu_start_int_o(cpu_int), .cpu_stall_o(stall), .boot_done_o(done)
   );

   int checks = 0, errors = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor, sampled on the falling edge
   int cyc, rel_cyc, cs_cyc, oe_cyc, we_cnt, done_cnt, int_cnt, late_rd, addr_err;
   int next_addr;
   logic [31:0] got_w [NW];

   always @(negedge clk) begin
      if (!rst_n) begin
         cyc = 0; rel_cyc = -1; cs_cyc = 0; oe_cyc = 0; we_cnt = 0;
         done_cnt = 0; int_cnt = 0; late_rd = 0; addr_err = 0; next_addr = BASE;
         for (int k = 0; k < NW; k++) got_w[k] = 32'h0;
      end else begin
         cyc++;
         if (!stall && rel_cyc < 0) rel_cyc = cyc;
         if (!rom_cs_n) cs_cyc++;
         if (!rom_oe_n) begin
            oe_cyc++;
            if (int'(rom_addr) != next_addr && int'(rom_addr) != next_addr + 1) addr_err++;
            if (int'(rom_addr) == next_addr + 1) next_addr++;
         end
         if (!rom_cs_n && !stall) late_rd++;
         if (mem_we) begin
            we_cnt++;
            got_w[int'(mem_addr) / WB] = mem_wdata;
         end
         if (done) done_cnt++;
         if (cpu_int) int_cnt++;
      end
   end

   function automatic logic [31:0] exp_word(input int k);
      return {rom_byte(BASE + 4*k + 3), rom_byte(BASE + 4*k + 2),
              rom_byte(BASE + 4*k + 1), rom_byte(BASE + 4*k)};
   endfunction

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic do_reset(input logic [1:0] m, input logic sd);
      rst_n = 1'b0; boot_mode = m; sdram_used = sd; sdram_ready = 1'b0;
      host_set = 1'b0; host_clr = 1'b0;
      tick(3);
      rst_n = 1'b1;
   endtask

   task automatic pulse_host(input logic s, input logic c);
      host_set = s; host_clr = c;
      tick(1);
      host_set = 1'b0; host_clr = 1'b0;
      tick(2);
   endtask

   // {mode[1:0], sdram_used, ready_at[7:0], host_at[7:0], copy, release}; 8'hFF = never
   localparam logic [20:0] VECS [8] = '{
      {2'b00, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b1},   // R3 direct start
      {2'b00, 1'b1, 8'd20, 8'hFF, 1'b0, 1'b1},   // R3 wait SDRAM ready
      {2'b11, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b1},   // R1 reserved code
      {2'b10, 1'b0, 8'hFF, 8'hFF, 1'b1, 1'b1},   // R4 ROM copy
      {2'b01, 1'b0, 8'hFF, 8'd30, 1'b0, 1'b1},   // R8 host start
      {2'b01, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b0},   // R8 host never starts
      {2'b00, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0},   // R3 SDRAM never ready
      {2'b10, 1'b0, 8'hFF, 8'd5,  1'b1, 1'b1}    // R8 host flag in ROM mode
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R2 reset state
      rst_n = 1'b0; tick(2);
      @(negedge clk);
      check(stall == 1'b1, "R2 stall in reset", stall, 1);
      check(rom_cs_n && rom_oe_n, "R2 ROM idle in reset", {rom_cs_n, rom_oe_n}, 3);
      check(!mem_we && !done && !flag && !cpu_int, "R2 outputs low in reset",
            {mem_we, done, flag, cpu_int}, 0);

      foreach (VECS[i]) begin
         automatic logic [1:0] m  = VECS[i][20:19];
         automatic logic       sd = VECS[i][18];
         automatic logic [7:0] ra = VECS[i][17:10];
         automatic logic [7:0] ha = VECS[i][9:2];
         automatic logic       cp = VECS[i][1];
         automatic logic       rl = VECS[i][0];
         do_reset(m, sd);
         for (int c = 0; c < 400; c++) begin
            @(posedge clk); #1;
            host_set = (ha != 8'hFF) && (c == int'(ha));
            if (ra != 8'hFF && c == int'(ra)) sdram_ready = 1'b1;
         end
         host_set = 1'b0;
         @(negedge clk);
         check((rel_cyc >= 0) == rl, $sformatf("R2 vec%0d release", i), rel_cyc, rl);
         check(done_cnt == int'(rl), $sformatf("R10 vec%0d done pulses", i), done_cnt, rl);
         check(int_cnt == 0, $sformatf("R9 vec%0d no int while stalled", i), int_cnt, 0);
         if (rl && m != 2'b10 && ra == 8'hFF && ha == 8'hFF)
            check(rel_cyc <= 3, $sformatf("R3 vec%0d prompt release", i), rel_cyc, 3);
         if (rl && ra != 8'hFF)
            check(rel_cyc > int'(ra), $sformatf("R3 vec%0d release after ready", i), rel_cyc, ra);
         if (rl && ha != 8'hFF && m == 2'b01)
            check(rel_cyc > int'(ha), $sformatf("R8 vec%0d release after start", i), rel_cyc, ha);
         if (cp) begin
            check(cs_cyc == BURST, $sformatf("R4 vec%0d burst length", i), cs_cyc, BURST);
            check(oe_cyc == IB * TT, $sformatf("R5 vec%0d strobe clocks", i), oe_cyc, IB * TT);
            check(addr_err == 0 && next_addr == BASE + IB - 1,
                  $sformatf("R4 vec%0d address order", i), next_addr, BASE + IB - 1);
            check(we_cnt == NW, $sformatf("R6 vec%0d word writes", i), we_cnt, NW);
            check(rel_cyc > BURST, $sformatf("R8 vec%0d stall through copy", i), rel_cyc, BURST);
            check(late_rd == 0, $sformatf("R7 vec%0d no read after release", i), late_rd, 0);
            for (int k = 0; k < NW; k++)
               if (got_w[k] !== exp_word(k))
                  check(1'b0, $sformatf("R6 vec%0d word %0d", i, k), got_w[k], exp_word(k));
            check(got_w[NW-1] === exp_word(NW-1), $sformatf("R6 vec%0d last word", i),
                  got_w[NW-1], exp_word(NW-1));
         end else begin
            check(cs_cyc == 0 && we_cnt == 0, $sformatf("R3 vec%0d no copy", i), cs_cyc + we_cnt, 0);
         end
      end

      // R1 mode change after sampling is ignored
      do_reset(2'b10, 1'b0);
      tick(3);
      boot_mode = 2'b01;
      tick(BURST + 20);
      @(negedge clk);
      check(we_cnt == NW, "R1 late mode change keeps ROM copy", we_cnt, NW);
      check(!stall, "R1 released without host start", stall, 0);

      // R9 flag behaviour after release in direct start
      do_reset(2'b00, 1'b0);
      tick(6);
      pulse_host(1'b1, 1'b0);
      @(negedge clk);
      check(flag == 1'b1, "R9 set raises flag", flag, 1);
      check(int_cnt == 1, "R9 first set interrupts", int_cnt, 1);
      pulse_host(1'b1, 1'b0);
      @(negedge clk);
      check(int_cnt == 1, "R9 no int while flag held", int_cnt, 1);
      pulse_host(1'b0, 1'b1);
      @(negedge clk);
      check(flag == 1'b0, "R9 clear drops flag", flag, 0);
      pulse_host(1'b1, 1'b1);
      @(negedge clk);
      check(flag == 1'b0 && int_cnt == 1, "R9 clear wins over set", {flag, 4'(int_cnt)}, 1);
      pulse_host(1'b1, 1'b0);
      @(negedge clk);
      check(int_cnt == 2, "R9 set after clear interrupts again", int_cnt, 2);

      // R9 host mode: set while stalled gives no int, re-set needs a clear
      do_reset(2'b01, 1'b0);
      tick(4);
      check(stall == 1'b1, "R8 host mode holds stall", stall, 1);
      pulse_host(1'b1, 1'b0);
      @(negedge clk);
      check(!stall && flag && int_cnt == 0, "R9 start while stalled: release, no int",
            {stall, flag, 4'(int_cnt)}, 16);
      pulse_host(1'b1, 1'b0);
      @(negedge clk);
      check(int_cnt == 0, "R9 uncleared flag blocks int", int_cnt, 0);
      pulse_host(1'b0, 1'b1);
      pulse_host(1'b1, 1'b0);
      @(negedge clk);
      check(int_cnt == 1, "R9 int after software clear", int_cnt, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule